// File: doc/BRIEF.md
# Self-Synchronising Bit Scrambler with Ones-Run Guard

This block whitens a serial transmit bit stream before it reaches a modulator. Each accepted bit is combined by XOR with two earlier outputs of the block itself, taken 14 and 17 bit times back. Because the delay line is loaded from the scrambled output and not from the raw input, a matching descrambler at the far end locks on by itself after 17 received bits. The same polynomial serves every line rate. The block advances only on an input strobe, so it works at any bit rate below the clock rate.

A guard watches the scrambled output for an unbroken run of ones. After 64 such ones, it inverts the next input bit before the XOR. This stops the feedback register from settling into an all-ones state, which an idle stream of ones would otherwise hold forever. Once the guard has fired, counting begins again from that bit.

Top module: `ones_guard_scrambler`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `out_valid`, `out_bit`, the 17-bit history and the ones-run count to zero. With an all-zero history, the first output equals the first input.
- R2: For each accepted bit, `out_bit` = `in_bit` XOR g XOR y(n-14) XOR y(n-17). Here y(n-k) is the scrambled bit produced k accepted bits earlier (zero if fewer have been produced since reset), and g is the guard flag from R5.
- R3: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. The matching `out_bit` appears in that same cycle, which gives a latency of one clock.
- R4: In a cycle with `in_valid` low, the block changes nothing. `out_bit` holds its value, and the history and run count are untouched, so later outputs equal those of a stream with the idle cycle removed.
- R5: When the last 64 scrambled bits since reset or the last guard action were all ones, g is 1 for the next accepted bit, so that input bit is inverted. Otherwise g is 0.
- R6: A scrambled zero clears the ones-run count to zero, so 63 ones, then a zero, then 63 ones do not trigger the guard.
- R7: After the guard fires, the run count restarts. The bit produced with the inversion counts as the first bit of the new run if it is a one. The next inversion needs another 64 ones counted from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: `in_bit` is accepted this cycle |
| in_bit | input | 1 | Unscrambled data bit |
| out_valid | output | 1 | High for one cycle per accepted bit, one clock after it |
| out_bit | output | 1 | Scrambled bit, held between strobes |

## Verification
The guard inversion and the tap feedback can act on the same bit, and the run count then restarts in the same cycle that produces a possible new one. The bench provokes this by choosing each input as the wanted output XOR the modelled taps, which drives the output to exactly 64 ones. It then sends a bit that would give a one without the guard. It checks that the output is a zero, that the next run of ones needs 64 more bits counting the inverted bit, and that a single zero in a 63-one run prevents the guard from firing.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int unsigned DEF_TAP_NEAR = 14;
  localparam int unsigned DEF_TAP_FAR  = 17;
  localparam int unsigned DEF_RUN_MAX  = 64;

  // Next value of the ones-run counter for one accepted bit.
  function automatic logic [7:0] run_next(input logic [7:0] cur,
                                          input logic       fired,
                                          input logic       bit_out);
    if (fired)        return {7'd0, bit_out};
    else if (bit_out) return cur + 8'd1;
    else              return 8'd0;
  endfunction
endpackage

// File: rtl/scr_delay_line.sv
module scr_delay_line #(
  parameter int unsigned DEPTH = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             d_in,
  output logic [DEPTH-1:0] q
);
  // q[k] holds the bit that entered k+1 accepted steps ago
  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    if (k == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst)           q[0] <= 1'b0;
        else if (shift_en) q[0] <= d_in;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst)           q[k] <= 1'b0;
        else if (shift_en) q[k] <= q[k-1];
      end
    end
  end
endmodule

// File: rtl/scr_run_guard.sv
module scr_run_guard
  import scr_pkg::*;
#(
  parameter int unsigned RUN_MAX = 64,
  parameter int unsigned CNT_W   = $clog2(RUN_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  input  logic             bit_out,
  output logic             fire,
  output logic [CNT_W-1:0] count
);
  logic [7:0] nxt_wide;

  assign fire = (count == CNT_W'(RUN_MAX));

  always_comb begin
    nxt_wide = run_next(8'(count), fire, bit_out);
  end

  always_ff @(posedge clk) begin
    if (rst)          count <= '0;
    else if (step_en) count <= nxt_wide[CNT_W-1:0];
  end
endmodule

// File: rtl/scr_out_stage.sv
module scr_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic d,
  output logic q_valid,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q       <= 1'b0;
    end else begin
      q_valid <= load;
      if (load) q <= d;
    end
  end
endmodule

// File: rtl/ones_guard_scrambler.sv
module ones_guard_scrambler
  import scr_pkg::*;
#(
  parameter int unsigned TAP_NEAR = DEF_TAP_NEAR,
  parameter int unsigned TAP_FAR  = DEF_TAP_FAR,
  parameter int unsigned RUN_MAX  = DEF_RUN_MAX
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_bit,
  output logic out_valid,
  output logic out_bit
);
  localparam int unsigned HIST  = TAP_FAR;
  localparam int unsigned CNT_W = $clog2(RUN_MAX + 1);

  logic [HIST-1:0]  hist;
  logic             tap_near_bit;
  logic             tap_far_bit;
  logic             guard_fire;
  logic [CNT_W-1:0] run_cnt;
  logic             guarded_in;
  logic             mixed;

  assign tap_near_bit = hist[TAP_NEAR-1];
  assign tap_far_bit  = hist[TAP_FAR-1];
  assign guarded_in   = in_bit ^ guard_fire;
  assign mixed        = guarded_in ^ tap_near_bit ^ tap_far_bit;

  scr_delay_line #(.DEPTH(HIST)) u_hist (
    .clk(clk), .rst(rst), .shift_en(in_valid), .d_in(mixed), .q(hist)
  );

  scr_run_guard #(.RUN_MAX(RUN_MAX), .CNT_W(CNT_W)) u_guard (
    .clk(clk), .rst(rst), .step_en(in_valid), .bit_out(mixed),
    .fire(guard_fire), .count(run_cnt)
  );

  scr_out_stage u_out (
    .clk(clk), .rst(rst), .load(in_valid), .d(mixed),
    .q_valid(out_valid), .q(out_bit)
  );
endmodule

// File: rtl/scr_checker.sv
module scr_checker #(
  parameter int unsigned RUN_MAX = 64,
  parameter int unsigned CNT_W   = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_bit,
  input logic             out_valid,
  input logic             out_bit,
  input logic             tap_near,
  input logic             tap_far,
  input logic [CNT_W-1:0] run_cnt
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_bit && run_cnt == '0));

  a_r2_mix: assert property (@(posedge clk) disable iff (rst)
    (in_valid && run_cnt != CNT_W'(RUN_MAX)) |=>
      (out_bit == ($past(in_bit) ^ $past(tap_near) ^ $past(tap_far))));

  a_r3_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r3_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_bit) && $stable(run_cnt)));

  a_r5_invert: assert property (@(posedge clk) disable iff (rst)
    (in_valid && run_cnt == CNT_W'(RUN_MAX)) |=>
      (out_bit != ($past(in_bit) ^ $past(tap_near) ^ $past(tap_far))));

  a_r5_bound: assert property (@(posedge clk) disable iff (rst)
    run_cnt <= CNT_W'(RUN_MAX));

  a_r6_zero_clears: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_bit) |-> (run_cnt == '0));

  a_r7_restart: assert property (@(posedge clk) disable iff (rst)
    (in_valid && run_cnt == CNT_W'(RUN_MAX)) |=> (run_cnt <= CNT_W'(1)));
endmodule

bind ones_guard_scrambler scr_checker #(.RUN_MAX(RUN_MAX), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
  .out_valid(out_valid), .out_bit(out_bit),
  .tap_near(tap_near_bit), .tap_far(tap_far_bit), .run_cnt(run_cnt)
);

// File: tb/test_ones_guard_scrambler.sv
module test_ones_guard_scrambler;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic out_valid;
  logic out_bit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model
  logic [16:0] m_hist = '0;
  int          m_cnt  = 0;
  bit          p_valid = 1'b0;
  bit          p_exp   = 1'b0;
  bit          p_last  = 1'b0;
  string       p_tag   = "R1";

  always #5 clk = ~clk;

  ones_guard_scrambler i_ones_guard_scrambler (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
    .out_valid(out_valid), .out_bit(out_bit)
  );

  function automatic bit model_taps();
    return m_hist[13] ^ m_hist[16];
  endfunction

  function automatic bit model_fire();
    return (m_cnt == 64);
  endfunction

  task automatic check(input string tag, input bit act, input bit exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // One cycle: judge the previous cycle's result, then drive the next input.
  task automatic step(input bit v, input bit b, input string tag);
    @(negedge clk);
    if (p_valid) begin
      check(p_tag, out_valid, 1'b1, "out_valid after strobe (R3)");
      check(p_tag, out_bit, p_exp, "out_bit");
    end else begin
      check(p_tag, out_valid, 1'b0, "out_valid idle (R3/R4)");
      check(p_tag, out_bit, p_last, "out_bit held (R4)");
    end
    in_valid = v;
    in_bit   = b;
    p_valid  = v;
    p_tag    = tag;
    if (v) begin
      bit f, d;
      f = model_fire();
      d = b ^ f ^ model_taps();
      m_hist = {m_hist[15:0], d};
      if (f)      m_cnt = d ? 1 : 0;
      else if (d) m_cnt = m_cnt + 1;
      else        m_cnt = 0;
      p_exp  = d;
      p_last = d;
    end
  endtask

  // Input chosen so that the output is the wanted bit, guard included.
  task automatic force_out(input bit want, input string tag);
    step(1'b1, want ^ model_taps() ^ model_fire(), tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; in_bit = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", out_valid, 1'b0, "out_valid in reset");
    check("R1", out_bit, 1'b0, "out_bit in reset");
    rst = 1'b0;
    m_hist = '0; m_cnt = 0;
    p_valid = 1'b0; p_last = 1'b0; p_tag = "R1";
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5C4A_3B17));
    do_reset();

    // R1: empty history passes first bits straight through
    step(1'b1, 1'b1, "R1");
    step(1'b1, 1'b0, "R1");
    step(1'b1, 1'b1, "R1");

    // R2/R3: random back-to-back stream
    for (int i = 0; i < 3000; i++) step(1'b1, 1'($urandom), "R2");

    // R4: random strobe gaps, output held while idle
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 3) == 0) step(1'b0, 1'($urandom), "R4");
      else                     step(1'b1, 1'($urandom), "R2");
    end

    // R5: exactly 64 ones at the output, then a bit that would be a one
    do_reset();
    for (int i = 0; i < 64; i++) force_out(1'b1, "R5");
    step(1'b1, 1'b1 ^ model_taps(), "R5");
    step(1'b0, 1'b0, "R5");
    check("R5", out_bit, 1'b0, "guarded bit inverted");

    // R6: 63 ones, a zero, 63 ones, then a bit that must not be inverted
    do_reset();
    for (int i = 0; i < 63; i++) force_out(1'b1, "R6");
    force_out(1'b0, "R6");
    for (int i = 0; i < 63; i++) force_out(1'b1, "R6");
    step(1'b1, 1'b1 ^ model_taps(), "R6");
    step(1'b0, 1'b0, "R6");
    check("R6", out_bit, 1'b1, "no inversion after broken run");

    // R7: guard fires with a one output; that one starts the new run
    do_reset();
    for (int i = 0; i < 64; i++) force_out(1'b1, "R7");
    step(1'b1, 1'b0 ^ model_taps(), "R7");   // inverted to a one
    for (int i = 0; i < 62; i++) force_out(1'b1, "R7");
    step(1'b1, 1'b1 ^ model_taps(), "R7");   // 64th one of new run, not inverted
    step(1'b1, 1'b1 ^ model_taps(), "R7");   // guard fires here
    step(1'b0, 1'b0, "R7");
    check("R7", out_bit, 1'b0, "second guard after restarted run");

    // long idle input of ones with gaps, model keeps judging
    for (int i = 0; i < 500; i++) step(($urandom % 4) != 0, 1'b1, "R5");
    step(1'b0, 1'b0, "R4");

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule